// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block holds a bank of 16-bit data pointers for an 8051-compatible processor core. Exactly one pointer is active at any time; which one is set by a small select register that software writes through the special-function-register (SFR) port. Every pointer action acts on the active pointer alone. These actions are a full 16-bit load from an instruction immediate, an increment, and byte-wide SFR reads and writes of its low and high halves. The pointers that are not selected keep their values, so code can switch between source and destination addresses with one SFR write and no save or restore.

The core's decoder drives a two-bit pointer command and the immediate value. The SFR port carries an address, write data and a write strobe, and returns read data combinationally. The active pointer is presented on a 16-bit address output, which the external data bus and the indexed code-read path use.

Top module: `dptr_bank`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, every pointer holds 0000h, the select value is 0 and ptr_addr reads 0000h.
- R2: An SFR write to address 92h stores bits [2:0] of the write data as the select value. A read of 92h returns the select value in bits [2:0] and 0 in bits [7:3].
- R3: Pointer command 2'b01 loads ptr_imm into the active pointer at the clock edge.
- R4: Pointer command 2'b10 increments the active pointer by one, with a carry from the low byte into the high byte, and FFFFh wraps to 0000h.
- R5: SFR address 82h reads and writes the low byte of the active pointer, and 83h its high byte. A byte write leaves the other byte and all other pointers unchanged.
- R6: Changing the select value leaves the contents of all eight pointers unchanged.
- R7: When a pointer update and a select write happen in the same cycle, the pointer update goes to the pointer chosen by the select value held before that edge.
- R8: A load or increment command takes priority over an SFR byte write to the active pointer in the same cycle. Commands 2'b00 and 2'b11 change nothing.
- R9: ptr_addr always shows the current value of the active pointer, with no added delay.
- R10: SFR reads of any address other than 82h, 83h and 92h return 00h, and writes to such addresses change no pointer and no select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data, combinational from sfr_addr |
| ptr_cmd | input | 2 | Pointer command: 00 idle, 01 load, 10 increment, 11 idle |
| ptr_imm | input | 16 | Immediate value for the load command |
| ptr_addr | output | 16 | Active pointer value |

## Verification
Directed patterns first fill each of the eight pointers with a distinct value and read each one back after switching. This separates a true bank from a shared register and from a select that does not decode. Increments at 00FFh and FFFFh show whether the carry into the high byte and the wrap are correct. Cycles that combine a command with a select write, or a command with a byte write, show which select value and which writer win. A long pseudo-random run then mixes all commands and SFR accesses, including unmapped addresses and select writes with the upper bits set. A behavioural model checks it on every clock.

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int NUM_PTR  = 8,
  parameter int PW       = 16,
  parameter int SAW      = 8,
  parameter logic [SAW-1:0] SEL_ADDR = 8'h92,
  parameter logic [SAW-1:0] LO_ADDR  = 8'h82,
  parameter logic [SAW-1:0] HI_ADDR  = 8'h83
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SAW-1:0] sfr_addr,
  input  logic [7:0]     sfr_wdata,
  input  logic           sfr_we,
  output logic [7:0]     sfr_rdata,
  input  logic [1:0]     ptr_cmd,
  input  logic [PW-1:0]  ptr_imm,
  output logic [PW-1:0]  ptr_addr
);
  localparam int SW = $clog2(NUM_PTR);
  localparam int HB = PW / 2;

  logic [PW-1:0] bank [NUM_PTR];
  logic [SW-1:0] sel_q;

  wire wr_sel = sfr_we && (sfr_addr == SEL_ADDR);
  wire wr_lo  = sfr_we && (sfr_addr == LO_ADDR);
  wire wr_hi  = sfr_we && (sfr_addr == HI_ADDR);
  wire do_ld  = (ptr_cmd == 2'b01);
  wire do_inc = (ptr_cmd == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= sfr_wdata[SW-1:0];
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    wire act = (sel_q == SW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) bank[i] <= '0;
      else if (act) begin
        if (do_ld)       bank[i] <= ptr_imm;
        else if (do_inc) bank[i] <= bank[i] + 1'b1;
        else begin
          if (wr_lo) bank[i][HB-1:0]  <= sfr_wdata[HB-1:0];
          if (wr_hi) bank[i][PW-1:HB] <= sfr_wdata[PW-HB-1:0];
        end
      end
    end
  end

  assign ptr_addr = bank[sel_q];

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == LO_ADDR)       sfr_rdata = ptr_addr[HB-1:0];
    else if (sfr_addr == HI_ADDR)  sfr_rdata = ptr_addr[PW-1:HB];
    else if (sfr_addr == SEL_ADDR) sfr_rdata[SW-1:0] = sel_q;
  end
endmodule

// File: rtl/dptr_bank_chk.sv
module dptr_bank_chk #(
  parameter int SAW = 8,
  parameter int PW  = 16,
  parameter logic [SAW-1:0] SEL_ADDR = 8'h92,
  parameter logic [SAW-1:0] LO_ADDR  = 8'h82
) (
  input logic           clk,
  input logic           rst_n,
  input logic [SAW-1:0] sfr_addr,
  input logic [7:0]     sfr_wdata,
  input logic           sfr_we,
  input logic [7:0]     sfr_rdata,
  input logic [1:0]     ptr_cmd,
  input logic [PW-1:0]  ptr_imm,
  input logic [PW-1:0]  ptr_addr
);
  wire sel_wr = sfr_we && (sfr_addr == SEL_ADDR);
  wire quiet  = !sfr_we && (ptr_cmd == 2'b00 || ptr_cmd == 2'b11);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_cmd == 2'b01 && !sel_wr) |=> ptr_addr == $past(ptr_imm));

  assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_cmd == 2'b10 && !sel_wr) |=> ptr_addr == PW'($past(ptr_addr) + 1'b1));

  assert_sel_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SEL_ADDR) |-> sfr_rdata[7:3] == 5'd0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(ptr_addr));

  assert_lo_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == LO_ADDR && ptr_cmd[0] == ptr_cmd[1])
      |=> (ptr_addr[7:0] == $past(sfr_wdata)) && (ptr_addr[PW-1:8] == $past(ptr_addr[PW-1:8])));
endmodule

bind dptr_bank dptr_bank_chk #(.SAW(SAW), .PW(PW), .SEL_ADDR(SEL_ADDR), .LO_ADDR(LO_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
  .sfr_rdata(sfr_rdata), .ptr_cmd(ptr_cmd), .ptr_imm(ptr_imm), .ptr_addr(ptr_addr)
);

// File: tb/tb_dptr_bank.sv
`timescale 1ns/1ps
module tb_dptr_bank;
  logic clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic sfr_we = 0;
  logic [1:0] ptr_cmd = 0;
  logic [15:0] ptr_imm = 0, ptr_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  int unsigned mdl [8];
  int unsigned msel = 0;

  always #4 clk = ~clk;

  dptr_bank dut (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ptr_cmd(ptr_cmd), .ptr_imm(ptr_imm),
    .ptr_addr(ptr_addr));

  function automatic int unsigned exp_rd(input logic [7:0] a);
    if (a == 8'h82) return mdl[msel] & 8'hFF;
    if (a == 8'h83) return (mdl[msel] >> 8) & 8'hFF;
    if (a == 8'h92) return msel;
    return 0;
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic we,
                     input logic [1:0] cmd, input logic [15:0] imm, input string req);
    int unsigned os;
    sfr_addr = a; sfr_wdata = d; sfr_we = we; ptr_cmd = cmd; ptr_imm = imm;
    #1;
    check({req, " ptr_addr"}, ptr_addr, mdl[msel]);
    check({req, " sfr_rdata"}, sfr_rdata, exp_rd(a));
    @(posedge clk);
    os = msel;
    if (cmd == 2'b01) mdl[os] = imm;
    else if (cmd == 2'b10) mdl[os] = (mdl[os] + 1) & 16'hFFFF;
    else begin
      if (we && a == 8'h82) mdl[os] = (mdl[os] & 16'hFF00) | d;
      if (we && a == 8'h83) mdl[os] = (mdl[os] & 16'h00FF) | (int'(d) << 8);
    end
    if (we && a == 8'h92) msel = d & 7;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    cyc(a, 8'h00, 1'b0, 2'b00, 16'h0, req);
  endtask

  task automatic sel(input int n, input string req);
    cyc(8'h92, 8'(n), 1'b1, 2'b00, 16'h0, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 8; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset ptr_addr", ptr_addr, 0);
    sfr_addr = 8'h92; #1;
    check("R1 reset select", sfr_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin sel(i, "R1"); rd(8'h82, "R1"); rd(8'h83, "R1"); end
    sel(0, "R2");
    // R3 / R6: fill every pointer, then read back each after switching
    for (int i = 0; i < 8; i++) begin
      sel(i, "R6");
      cyc(8'h00, 8'h00, 1'b0, 2'b01, 16'(16'h1111 * (i + 1) + i), "R3");
    end
    for (int i = 7; i >= 0; i--) begin sel(i, "R6"); rd(8'h82, "R6"); rd(8'h83, "R6"); end
    // R4 carry and wrap
    sel(2, "R4");
    cyc(8'h00, 8'h00, 1'b0, 2'b01, 16'h00FF, "R4");
    cyc(8'h00, 8'h00, 1'b0, 2'b10, 16'h0, "R4 carry");
    rd(8'h83, "R4 carry");
    cyc(8'h00, 8'h00, 1'b0, 2'b01, 16'hFFFF, "R4");
    cyc(8'h00, 8'h00, 1'b0, 2'b10, 16'h0, "R4 wrap");
    rd(8'h82, "R4 wrap");
    // R5 byte writes
    cyc(8'h82, 8'h5A, 1'b1, 2'b00, 16'h0, "R5 lo");
    cyc(8'h83, 8'hC3, 1'b1, 2'b00, 16'h0, "R5 hi");
    rd(8'h82, "R5"); rd(8'h83, "R5");
    sel(3, "R5"); rd(8'h82, "R5 other"); rd(8'h83, "R5 other");
    // R7 same-cycle select write with load / increment
    cyc(8'h92, 8'h04, 1'b1, 2'b01, 16'hBEEF, "R7 load");
    sel(3, "R7"); rd(8'h83, "R7 old sel got load");
    cyc(8'h92, 8'h06, 1'b1, 2'b10, 16'h0, "R7 inc");
    sel(3, "R7"); rd(8'h82, "R7 old sel got inc");
    // R8 command priority and idle command 11
    cyc(8'h82, 8'h11, 1'b1, 2'b01, 16'h2468, "R8 load over byte");
    cyc(8'h83, 8'h99, 1'b1, 2'b10, 16'h0, "R8 inc over byte");
    cyc(8'h00, 8'h00, 1'b0, 2'b11, 16'h7777, "R8 cmd11");
    rd(8'h82, "R8"); rd(8'h83, "R8");
    // R2 upper select bits, R10 unmapped
    sel(8'hFD, "R2"); rd(8'h92, "R2 upper zero");
    cyc(8'h81, 8'h42, 1'b1, 2'b00, 16'h0, "R10 write");
    rd(8'h81, "R10 read"); rd(8'h92, "R10 sel kept"); rd(8'h82, "R10");
    // R9 mixed pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: a = 8'h92;
        3'd2: a = 8'h82;
        3'd3: a = 8'h83;
        3'd4: a = 8'hE0;
        default: a = lfsr[10:3];
      endcase
      cyc(a, lfsr[15:8], lfsr[5], lfsr[7:6], {lfsr[3:0], lfsr[15:4]}, "R9 random");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule